// File: doc/BRIEF.md
# Parallel Three-Register Nonlinear Shift Stream Cipher

This block is a keystream generator and XOR stage built from three nonlinear feedback shift registers. Together they hold 288 bits of state, in registers of 93, 84 and 111 bits. A compile-time factor `D` unrolls the state update `D` times, so each clock advances the state by `D` positions and yields `D` keystream bits. Throughput grows with `D`, and the feedback logic is copied once per step.

The user loads the 80-bit key and then the 80-bit IV, one bit per handshake, on the serial key port. After the 160th bit the block runs 1152 silent warm-up updates. These take `1152/D` clocks. It then accepts plaintext words of `D` bits. Each accepted word is XORed with the next `D` keystream bits and leaves on the ciphertext port one clock later. A downstream full flag throttles acceptance. The block stays in keystream mode until reset.

The controller has three named states. `PH_LOAD` takes key and IV bits. `PH_WARM` runs the initialization updates. `PH_RUN` encrypts words. There are two transitions. `T_LOAD_DONE` goes from `PH_LOAD` to `PH_WARM` on the edge that accepts the 160th serial bit. `T_WARM_DONE` goes from `PH_WARM` to `PH_RUN` on the last warm-up clock. Reset always returns the controller to `PH_LOAD`.

Top module: `nfsr_stream_cipher`

## Requirements
- R1: While reset is low and on release, `kv_ready` is 1, `pt_ready` is 0 and `ct_push` is 0.
- R2: A serial bit is taken on each clock where `kv_push` and `kv_ready` are both high. The n-th taken bit (n = 1..160) sets state bit s_n for n ≤ 80 (first register, key) and s_(n+13) for n > 80 (second register, IV). `kv_ready` falls on the edge that takes the 160th bit.
- R3: All state bits not written by loading are 0, except s286, s287 and s288, which are 1.
- R4: After loading, the state makes 1152 updates (1152/D clocks) with `pt_ready` low and no `ct_push`. Then `pt_ready` is high whenever `ct_full` is low.
- R5: One update computes t1 = s66^s93, t2 = s162^s177 and t3 = s243^s288, with keystream bit z = t1^t2^t3. The three registers then shift by one place. s1 receives t3^(s286&s287)^s69, s94 receives t1^(s91&s92)^s171, and s178 receives t2^(s175&s176)^s264. Bit j of `ct_word` is bit j of the accepted word XOR the j-th of the next D keystream bits, with bit 0 first.
- R6: The state advances only for accepted words. Idle clocks in keystream mode skip no keystream bits.
- R7: `pt_ready` is low in every clock where `ct_full` is high. No `ct_push` follows a clock in which `ct_full` was high.
- R8: `ct_push` is high for exactly one clock, the one after each accepted word, and is low otherwise.
- R9: D is between 1 and 64 and divides 1152. The block produces the same keystream bit sequence for D = 1 and D = 64.
- R10: `kv_push` is ignored once loading is complete. It does not change the keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| kv_bit | input | 1 | Serial key/IV bit |
| kv_push | input | 1 | Offers `kv_bit` this clock |
| kv_ready | output | 1 | Block is taking serial key/IV bits |
| pt_word | input | D | Plaintext word, bit 0 pairs with the first keystream bit |
| pt_push | input | 1 | Offers `pt_word` this clock |
| pt_ready | output | 1 | Block accepts a plaintext word this clock |
| ct_word | output | D | Ciphertext word |
| ct_push | output | 1 | `ct_word` valid this clock |
| ct_full | input | 1 | Downstream cannot take a word next clock |

## Verification
`kv_ready` and `pt_ready` depend only on the controller state and on `ct_full` in the same clock. The bench therefore checks them in the middle of the clock in which the inputs were applied. The ciphertext of a word accepted at one rising edge is due in the clock after that edge. The bench updates its behavioural model at that edge and compares `ct_push` and `ct_word` on the following falling edge. The end of warm-up is predicted by counting exactly 1152/D edges after the edge that takes the last serial bit. A second instance with D = 1 collects its output bits, and the bench compares them with the same model keystream.

// File: rtl/nfsr_cipher_pkg.sv
package nfsr_cipher_pkg;

    localparam int STATE_BITS = 288;
    localparam int KEY_BITS   = 80;
    localparam int IV_BITS    = 80;
    localparam int LOAD_BITS  = KEY_BITS + IV_BITS;
    localparam int WARM_STEPS = 4 * STATE_BITS;
    localparam int MAX_PAR    = 64;

    // register lengths and offsets (0-based into the 288-bit vector)
    localparam int REG_A_LEN  = 93;
    localparam int REG_B_LEN  = 84;
    localparam int REG_C_LEN  = 111;
    localparam int REG_B_BASE = REG_A_LEN;
    localparam int REG_C_BASE = REG_A_LEN + REG_B_LEN;
    localparam int IV_SHIFT   = REG_B_BASE - KEY_BITS;

    // tap positions, 0-based (position n in 1-based numbering is n-1)
    localparam int TAP_A_LIN  = 65;
    localparam int TAP_A_END  = 92;
    localparam int TAP_A_AND0 = 90;
    localparam int TAP_A_AND1 = 91;
    localparam int TAP_A_XB   = 170;
    localparam int TAP_B_LIN  = 161;
    localparam int TAP_B_END  = 176;
    localparam int TAP_B_AND0 = 174;
    localparam int TAP_B_AND1 = 175;
    localparam int TAP_B_XC   = 263;
    localparam int TAP_C_LIN  = 242;
    localparam int TAP_C_END  = 287;
    localparam int TAP_C_AND0 = 285;
    localparam int TAP_C_AND1 = 286;
    localparam int TAP_C_XA   = 68;

    typedef logic [STATE_BITS-1:0] state_vec_t;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_WARM = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;

    localparam state_vec_t SEED_STATE = {3'b111, {(STATE_BITS-3){1'b0}}};

endpackage

// File: rtl/nfsr_step.sv
module nfsr_step
    import nfsr_cipher_pkg::*;
(
    input  state_vec_t cur,
    output state_vec_t nxt,
    output logic       ks
);
    logic lin_a, lin_b, lin_c;
    logic fb_a, fb_b, fb_c;

    always_comb begin
        lin_a = cur[TAP_A_LIN] ^ cur[TAP_A_END];
        lin_b = cur[TAP_B_LIN] ^ cur[TAP_B_END];
        lin_c = cur[TAP_C_LIN] ^ cur[TAP_C_END];
        ks    = lin_a ^ lin_b ^ lin_c;
        // each register's head is fed from the previous register's taps
        fb_b  = lin_a ^ (cur[TAP_A_AND0] & cur[TAP_A_AND1]) ^ cur[TAP_A_XB];
        fb_c  = lin_b ^ (cur[TAP_B_AND0] & cur[TAP_B_AND1]) ^ cur[TAP_B_XC];
        fb_a  = lin_c ^ (cur[TAP_C_AND0] & cur[TAP_C_AND1]) ^ cur[TAP_C_XA];
        nxt[REG_B_BASE-1:0]          = {cur[REG_B_BASE-2:0], fb_a};
        nxt[REG_C_BASE-1:REG_B_BASE] = {cur[REG_C_BASE-2:REG_B_BASE], fb_b};
        nxt[STATE_BITS-1:REG_C_BASE] = {cur[STATE_BITS-2:REG_C_BASE], fb_c};
    end

endmodule

// File: rtl/nfsr_core.sv
module nfsr_core
    import nfsr_cipher_pkg::*;
#(
    parameter int D = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [7:0]   load_idx,
    input  logic         load_bit,
    input  logic         adv,
    output logic [D-1:0] ks_word
);
    state_vec_t state;
    state_vec_t chain [0:D];
    logic [8:0] load_pos;

    assign chain[0] = state;

    generate
        for (genvar g = 0; g < D; g++) begin : g_unroll
            nfsr_step u_step (
                .cur (chain[g]),
                .nxt (chain[g+1]),
                .ks  (ks_word[g])
            );
        end
    endgenerate

    always_comb begin
        if (load_idx < 8'(KEY_BITS))
            load_pos = {1'b0, load_idx};
        else
            load_pos = {1'b0, load_idx} + 9'(IV_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED_STATE;
        else if (load_en)
            state[load_pos] <= load_bit;
        else if (adv)
            state <= chain[D];
    end

    initial begin
        a_r9_par_legal: assert (D >= 1 && D <= MAX_PAR && (WARM_STEPS % D) == 0)
            else $error("parallel factor out of range");
    end

    // R6: with no load and no advance the state holds
    a_r6_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !adv) |=> $stable(state));

endmodule

// File: rtl/nfsr_ctrl.sv
module nfsr_ctrl
    import nfsr_cipher_pkg::*;
#(
    parameter int D = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kv_push,
    input  logic       pt_push,
    input  logic       ct_full,
    output logic       kv_ready,
    output logic       pt_ready,
    output logic       load_en,
    output logic [7:0] load_idx,
    output logic       adv,
    output logic       take
);
    localparam int WARM_CLKS = WARM_STEPS / D;
    localparam int WCW       = (WARM_CLKS > 1) ? $clog2(WARM_CLKS) : 1;

    phase_t         phase, phase_nx;
    logic [7:0]     load_cnt;
    logic [WCW-1:0] warm_cnt;
    logic           t_load_done, t_warm_done;

    assign t_load_done = load_en && (load_cnt == 8'(LOAD_BITS - 1));
    assign t_warm_done = (phase == PH_WARM) && (warm_cnt == WCW'(WARM_CLKS - 1));

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_LOAD: if (t_load_done) phase_nx = PH_WARM;
            PH_WARM: if (t_warm_done) phase_nx = PH_RUN;
            PH_RUN:  phase_nx = PH_RUN;
            default: phase_nx = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_LOAD;
            load_cnt <= '0;
            warm_cnt <= '0;
        end else begin
            phase <= phase_nx;
            if (load_en)
                load_cnt <= load_cnt + 8'd1;
            if (phase == PH_WARM)
                warm_cnt <= warm_cnt + WCW'(1);
        end
    end

    always_comb begin
        kv_ready = 1'b0;
        pt_ready = 1'b0;
        adv      = 1'b0;
        unique case (phase)
            PH_LOAD: kv_ready = 1'b1;
            PH_WARM: adv      = 1'b1;
            PH_RUN: begin
                pt_ready = !ct_full;
                adv      = pt_push && !ct_full;
            end
            default: ;
        endcase
        load_en  = kv_push && kv_ready;
        take     = pt_push && pt_ready;
        load_idx = load_cnt;
    end

    // R2: loading closes only on the 160th accepted bit
    a_r2_load_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kv_ready) |-> $past(load_en && load_cnt == 8'(LOAD_BITS - 1)));

    // R4: keystream mode, once reached, is never left
    a_r4_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |=> (phase == PH_RUN));

    // R4: the first keystream clock follows the full warm-up count
    a_r4_warm_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase == PH_RUN) |-> $past(warm_cnt == WCW'(WARM_CLKS - 1)));

endmodule

// File: rtl/nfsr_stream_cipher.sv
module nfsr_stream_cipher
    import nfsr_cipher_pkg::*;
#(
    parameter int D = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kv_bit,
    input  logic         kv_push,
    output logic         kv_ready,
    input  logic [D-1:0] pt_word,
    input  logic         pt_push,
    output logic         pt_ready,
    output logic [D-1:0] ct_word,
    output logic         ct_push,
    input  logic         ct_full
);
    logic         load_en, adv, take;
    logic [7:0]   load_idx;
    logic [D-1:0] ks_word;

    nfsr_ctrl #(.D(D)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .kv_push  (kv_push),
        .pt_push  (pt_push),
        .ct_full  (ct_full),
        .kv_ready (kv_ready),
        .pt_ready (pt_ready),
        .load_en  (load_en),
        .load_idx (load_idx),
        .adv      (adv),
        .take     (take)
    );

    nfsr_core #(.D(D)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_idx (load_idx),
        .load_bit (kv_bit),
        .adv      (adv),
        .ks_word  (ks_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_push <= 1'b0;
            ct_word <= '0;
        end else begin
            ct_push <= take;
            if (take)
                ct_word <= pt_word ^ ks_word;
        end
    end

    // R8: every output word comes from an accepted input one clock earlier
    a_r8_push_origin: assert property (@(posedge clk) disable iff (!rst_n)
        ct_push |-> $past(pt_push && pt_ready));

    // R7: nothing is written after a clock with the full flag raised
    a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ct_full) |-> !ct_push);

    // R1: the serial port and the word port are never open together
    a_r1_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(kv_ready && pt_ready));

endmodule

// File: tb/sim_nfsr_stream_cipher.sv
module sim_nfsr_stream_cipher;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 64;
    localparam int KS_LEN     = 4096;
    localparam int RUN_CYCLES = 1700;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kv_bit = 1'b0, kv_push = 1'b0;
    logic          kv_ready, pt_ready, ct_push;
    logic [DW-1:0] pt_word = '0, ct_word;
    logic          pt_push = 1'b0, ct_full = 1'b0;
    logic          u1_kv_ready, u1_pt_ready, u1_push;
    logic [0:0]    u1_ct;

    int n_chk = 0, n_bad = 0;
    bit s [1:288];
    bit ks [0:KS_LEN-1];
    bit ld [0:159];
    bit u1_bits [0:511];
    int u1_n = 0;
    int m_loaded = 0, m_warm = 0, ks_pos = 0, m_words = 0;
    bit m_run = 0, exp_push = 0, gap_seen = 0;
    logic [DW-1:0] exp_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    nfsr_stream_cipher #(.D(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .kv_bit(kv_bit), .kv_push(kv_push),
        .kv_ready(kv_ready), .pt_word(pt_word), .pt_push(pt_push),
        .pt_ready(pt_ready), .ct_word(ct_word), .ct_push(ct_push),
        .ct_full(ct_full)
    );

    nfsr_stream_cipher #(.D(1)) u1 (
        .clk(clk), .rst_n(rst_n), .kv_bit(kv_bit), .kv_push(kv_push),
        .kv_ready(u1_kv_ready), .pt_word(1'b0), .pt_push(1'b1),
        .pt_ready(u1_pt_ready), .ct_word(u1_ct), .ct_push(u1_push),
        .ct_full(1'b0)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit src_bit(input int i);
        if (i < 80) return ((i * 13 + 5) % 7) < 3;
        return (((i - 80) * 5 + 1) % 3) == 0;
    endfunction

    // behavioural model of one update, 1-based positions
    function automatic bit model_step();
        bit a, b, c, z, na, nb, nc;
        a = s[66] ^ s[93];
        b = s[162] ^ s[177];
        c = s[243] ^ s[288];
        z = a ^ b ^ c;
        nb = a ^ (s[91] & s[92]) ^ s[171];
        nc = b ^ (s[175] & s[176]) ^ s[264];
        na = c ^ (s[286] & s[287]) ^ s[69];
        for (int i = 288; i > 178; i--) s[i] = s[i-1];
        for (int i = 177; i > 94; i--) s[i] = s[i-1];
        for (int i = 93; i > 1; i--) s[i] = s[i-1];
        s[1] = na; s[94] = nb; s[178] = nc;
        return z;
    endfunction

    task automatic model_seed();
        bit z;
        for (int i = 1; i <= 288; i++) s[i] = 1'b0;
        for (int i = 1; i <= 80; i++) s[i] = ld[i-1];
        for (int i = 1; i <= 80; i++) s[93+i] = ld[79+i];
        s[286] = 1'b1; s[287] = 1'b1; s[288] = 1'b1;
        for (int i = 0; i < 1152; i++) z = model_step();
        for (int i = 0; i < KS_LEN; i++) ks[i] = model_step();
    endtask

    always @(negedge clk) begin
        if (rst_n && u1_push && u1_n < 512) begin
            u1_bits[u1_n] = u1_ct[0];
            u1_n++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog expired act=%0d exp=%0d", 20000, RUN_CYCLES);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit kv_acc, pt_acc, exp_rdy;
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        chk(kv_ready === 1'b1, "R1 kv_ready", 64'(kv_ready), 64'd1);
        chk(pt_ready === 1'b0, "R1 pt_ready", 64'(pt_ready), 64'd0);
        chk(ct_push === 1'b0, "R1 ct_push", 64'(ct_push), 64'd0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            if (m_loaded < 160) begin
                kv_push = (cyc % 7) != 3;
                kv_bit  = src_bit(m_loaded);
            end else begin
                kv_push = (cyc % 5) == 0;   // R10: pushes after loading
                kv_bit  = cyc[0];
            end
            pt_push = ((cyc % 5) != 2) && (m_words < 60);
            pt_word = {32'(cyc * 32'h9E3779B9), 32'(cyc) ^ 32'h5A5A1234};
            ct_full = (cyc % 11) >= 8;
            #1;
            chk(kv_ready === (m_loaded < 160), "R2/R10 kv_ready",
                64'(kv_ready), 64'(m_loaded < 160));
            exp_rdy = m_run && !ct_full;
            chk(pt_ready === exp_rdy, "R4/R7 pt_ready", 64'(pt_ready), 64'(exp_rdy));
            kv_acc = kv_push && (m_loaded < 160);
            pt_acc = pt_push && exp_rdy;
            if (m_run && !pt_acc) gap_seen = 1'b1;
            @(posedge clk);
            if (m_warm > 0) m_warm--;
            if (kv_acc) begin
                ld[m_loaded] = kv_bit;
                m_loaded++;
                if (m_loaded == 160) begin
                    model_seed();
                    m_warm = 1152 / DW;
                end
            end
            exp_push = pt_acc;
            if (pt_acc) begin
                for (int j = 0; j < DW; j++) exp_word[j] = pt_word[j] ^ ks[ks_pos + j];
                ks_pos += DW;
                m_words++;
            end
            m_run = (m_loaded == 160) && (m_warm == 0);
            @(negedge clk);
            chk(ct_push === exp_push, "R8 ct_push", 64'(ct_push), 64'(exp_push));
            if (exp_push) begin
                if (m_words == 1)
                    chk(ct_word === exp_word, "R3 first word", ct_word, exp_word);
                else if (gap_seen)
                    chk(ct_word === exp_word, "R5/R6 word", ct_word, exp_word);
                else
                    chk(ct_word === exp_word, "R5 word", ct_word, exp_word);
            end
        end
        // R9: D = 1 instance yields the same bit sequence
        chk(u1_n >= 256, "R9 u1 count", 64'(u1_n), 64'd256);
        for (int i = 0; i < 256 && i < u1_n; i++)
            chk(u1_bits[i] == ks[i], "R9 bit", 64'(u1_bits[i]), 64'(ks[i]));
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule